// File: doc/BRIEF.md
# Configurable UART frame transmitter

This block turns one character at a time into an asynchronous serial frame on a single line. The frame shape is chosen at run time through plain control pins: five to eight data bits, one, one-and-a-half or two stop bits, even, odd or forced parity, or no parity at all. A break request pulls the line low for as long as it is held. Bit timing comes from an external tick that pulses once per sixteenth of a bit period.

Characters arrive on a valid/ready stream. `in_ready` is high only while the transmitter is idle and neither a break nor a soft reset is requested. A character moves across on a clock edge where both `in_valid` and `in_ready` are high. The sender must hold `in_valid` and `in_data` steady until that happens. At the edge of acceptance the block copies the data and the whole frame format into its own registers, so the control pins may change freely during a frame. A synchronous soft reset drops the frame being sent and puts the copied format back to its default of six data bits, two stops and no parity.

Top module: `uart_frame_tx`

## Requirements
- R1: A frame is a low start bit, then the data bits least significant first, then the optional parity bit, then the stop bits. The word-length code `wlen` selects 5 (00), 6 (01), 7 (10) or 8 (11) data bits. Data bits above the selected length are ignored.
- R2: With `stop_sel`=0 the stop section lasts 16 ticks. With `stop_sel`=1 it lasts 24 ticks for 5-bit words and 32 ticks for 6, 7 or 8-bit words. The line is high during the stop section.
- R3: With `par_en`=1 and `par_force`=0, a parity bit follows the data. It makes the number of ones among data and parity even when `par_even`=1 and odd when `par_even`=0. With `par_en`=0 no parity bit is sent.
- R4: With `par_en`=1 and `par_force`=1, the parity bit is 1 when `par_even`=0 and 0 when `par_even`=1, whatever the data.
- R5: While `brk` is 1, `tx` is low in that same cycle and `in_ready` is low. A frame in progress is dropped, and `busy` is low from the cycle after `brk` rises. Normal operation resumes after `brk` returns to 0.
- R6: A cycle with `soft_rst`=1 ends any frame. From the next cycle, `busy` is low and `tx` is high (unless `brk` is set). `in_ready` is low while `soft_rst` is 1.
- R7: `in_ready` = idle and not `brk` and not `soft_rst`. A character is taken on an edge where `in_valid` and `in_ready` are both 1. `in_valid` has no effect while `in_ready` is 0. `busy` is high from the cycle after acceptance until the stop section ends.
- R8: Every start, data and parity bit lasts exactly 16 ticks. The line changes only on ticks. The format used is the one present on the pins at acceptance, so later changes to the controls do not change the current frame.
- R9: After reset, `tx` is high, `busy` is low and `in_ready` is high. The line stays high while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous channel reset, aborts the frame |
| wlen | input | 2 | Word-length code (5 to 8 data bits) |
| stop_sel | input | 1 | Longer stop section when 1 |
| par_en | input | 1 | Parity bit enable |
| par_even | input | 1 | Even parity when 1, odd when 0 |
| par_force | input | 1 | Forced parity value (inverse of `par_even`) |
| brk | input | 1 | Hold the line low (break) |
| tick16 | input | 1 | One pulse per sixteenth of a bit |
| in_data | input | 8 | Character to send |
| in_valid | input | 1 | Stream valid |
| in_ready | output | 1 | Stream ready |
| tx | output | 1 | Serial line, idle high |
| busy | output | 1 | Frame in progress |

## Verification
The bench targets the cases where the stop length and the parity both depend on the word length. One and a half stops at five bits would come out two bits long if the length coupling were lost. Forced parity against both parity selects would show up as a data-dependent parity bit if the force path were dropped. The bench changes every control in the middle of a frame, which catches a design that reads the pins live instead of its copy. It also asserts break and soft reset in the middle of a data bit and holds `in_valid` high during the break. A design that finishes the dropped frame, or takes a character while ready is low, would then show a line level that differs from the tick-level model.

// File: rtl/uft_pkg.sv
package uft_pkg;
  localparam int DATA_W = 8;
  localparam int IDX_W  = $clog2(DATA_W);

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_DATA,
    PH_PAR,
    PH_STOP
  } phase_e;

  typedef struct packed {
    logic [1:0] wlen;
    logic       stop_long;
    logic       par_en;
    logic       par_even;
    logic       par_force;
  } fmt_t;

  localparam fmt_t FMT_DEFAULT = '{wlen: 2'b01, stop_long: 1'b1, par_en: 1'b0,
                                   par_even: 1'b0, par_force: 1'b0};

  function automatic logic [3:0] word_bits(input logic [1:0] code);
    return 4'd5 + {2'b00, code};
  endfunction
endpackage

// File: rtl/uft_parity.sv
module uft_parity
  import uft_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  input  logic [3:0]        nbits,
  input  fmt_t              fmt,
  output logic              par_bit
);
  logic ones_odd;

  always_comb begin
    ones_odd = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < int'(nbits)) ones_odd = ones_odd ^ data[i];
    end
    if (fmt.par_force) par_bit = ~fmt.par_even;
    else if (fmt.par_even) par_bit = ones_odd;
    else par_bit = ~ones_odd;
  end
endmodule

// File: rtl/uft_tick_timer.sv
module uft_tick_timer #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          done
);
  logic [CW-1:0] cnt;

  assign done = !clr && tick && (cnt == limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (clr || done) cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end

  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < limit);
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uft_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic [1:0]        wlen,
  input  logic              stop_sel,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              par_force,
  input  logic              brk,
  input  logic              tick16,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              tx,
  output logic              busy
);
  localparam int CW = $clog2(2 * TICKS_PER_BIT + 1);
  localparam logic [CW-1:0] LIM_ONE  = CW'(TICKS_PER_BIT);
  localparam logic [CW-1:0] LIM_HALF = CW'(TICKS_PER_BIT + TICKS_PER_BIT / 2);
  localparam logic [CW-1:0] LIM_TWO  = CW'(2 * TICKS_PER_BIT);

  phase_e            phase;
  fmt_t              fmt_q;
  logic [DATA_W-1:0] data_q;
  logic [IDX_W-1:0]  bit_idx;
  logic [3:0]        nbits;
  logic [CW-1:0]     limit;
  logic              accept, done, par_bit, last_bit;
  fmt_t              fmt_in;

  assign fmt_in   = '{wlen: wlen, stop_long: stop_sel, par_en: par_en,
                      par_even: par_even, par_force: par_force && par_en};
  assign in_ready = (phase == PH_IDLE) && !brk && !soft_rst;
  assign accept   = in_valid && in_ready;
  assign busy     = (phase != PH_IDLE);
  assign nbits    = word_bits(fmt_q.wlen);
  assign last_bit = ({1'b0, bit_idx} == IDX_W'(nbits - 4'd1));

  always_comb begin
    limit = LIM_ONE;
    if (phase == PH_STOP && fmt_q.stop_long)
      limit = (fmt_q.wlen == 2'b00) ? LIM_HALF : LIM_TWO;
  end

  uft_tick_timer #(.CW(CW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   ((phase == PH_IDLE) || brk || soft_rst),
    .tick  (tick16),
    .limit (limit),
    .done  (done)
  );

  uft_parity u_parity (
    .data    (data_q),
    .nbits   (nbits),
    .fmt     (fmt_q),
    .par_bit (par_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      fmt_q   <= FMT_DEFAULT;
      data_q  <= '0;
      bit_idx <= '0;
    end else if (soft_rst) begin
      phase   <= PH_IDLE;
      fmt_q   <= FMT_DEFAULT;
      bit_idx <= '0;
    end else if (brk) begin
      phase   <= PH_IDLE;
      bit_idx <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (accept) begin
          phase   <= PH_START;
          fmt_q   <= fmt_in;
          data_q  <= in_data;
          bit_idx <= '0;
        end
        PH_START: if (done) phase <= PH_DATA;
        PH_DATA: if (done) begin
          if (last_bit) phase <= fmt_q.par_en ? PH_PAR : PH_STOP;
          else bit_idx <= bit_idx + 1'b1;
        end
        PH_PAR:  if (done) phase <= PH_STOP;
        PH_STOP: if (done) phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (phase)
      PH_START: tx = 1'b0;
      PH_DATA:  tx = data_q[bit_idx];
      PH_PAR:   tx = par_bit;
      default:  tx = 1'b1;
    endcase
    if (brk) tx = 1'b0;
  end

  p_accept_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  p_break_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    brk |=> !busy);
  p_soft_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !busy);
  p_start_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !tx);
  p_fmt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(soft_rst)) |-> $stable(fmt_q));
  p_stop_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_STOP && !brk) |-> tx);
endmodule

// File: tb/test_uart_frame_tx.sv
module test_uart_frame_tx;
  localparam int CLK_PERIOD = 10;
  localparam int TPB = 16;

  logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0;
  logic [1:0] wlen = 2'b11;
  logic stop_sel = 1'b0, par_en = 1'b0, par_even = 1'b0, par_force = 1'b0;
  logic brk = 1'b0, tick16 = 1'b0, in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, tx, busy;

  int errors = 0, checks = 0, tcnt = 0;
  bit finished = 1'b0;
  string cur_req = "R9";
  bit q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_frame_tx #(.TICKS_PER_BIT(TPB)) i_uart_frame_tx (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wlen(wlen), .stop_sel(stop_sel),
    .par_en(par_en), .par_even(par_even), .par_force(par_force), .brk(brk),
    .tick16(tick16), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .tx(tx), .busy(busy)
  );

  function automatic bit exp_ready();
    return (q.size() == 0) && !brk && !soft_rst;
  endfunction

  task automatic push_level(input bit v, input int n);
    for (int k = 0; k < n; k++) q.push_back(v);
  endtask

  task automatic build_frame();
    int nb, ones;
    bit pb;
    nb = 5 + int'(wlen);
    ones = 0;
    push_level(1'b0, TPB);
    for (int i = 0; i < nb; i++) begin
      push_level(in_data[i], TPB);
      ones += int'(in_data[i]);
    end
    if (par_en) begin
      if (par_force) pb = !par_even;
      else if (par_even) pb = (ones % 2) == 1;
      else pb = (ones % 2) == 0;
      push_level(pb, TPB);
    end
    if (!stop_sel) push_level(1'b1, TPB);
    else if (wlen == 2'b00) push_level(1'b1, TPB + TPB / 2);
    else push_level(1'b1, 2 * TPB);
  endtask

  // Tick-level reference: one queue entry per line level per tick.
  always @(posedge clk) begin
    if (!rst_n || soft_rst || brk) q.delete();
    else if (q.size() != 0) begin
      if (tick16) void'(q.pop_front());
    end else if (in_valid && exp_ready()) build_frame();
  end

  task automatic check1(input string what, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check1("tx", tx, brk ? 1'b0 : (q.size() != 0 ? q[0] : 1'b1));
      check1("busy", busy, q.size() != 0);
      check1("in_ready", in_ready, exp_ready());
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      #1;
      tick16 = (tcnt % 3 == 0);
      tcnt++;
    end
  end

  task automatic set_fmt(input logic [1:0] w, input bit s, input bit pe,
                         input bit ev, input bit fo);
    wlen = w; stop_sel = s; par_en = pe; par_even = ev; par_force = fo;
  endtask

  task automatic send(input logic [7:0] d);
    in_data = d;
    in_valid = 1'b1;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy || q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cur_req = "R9";
    @(negedge clk);
    check1("reset tx", tx, 1'b1);
    check1("reset busy", busy, 1'b0);
    check1("reset in_ready", in_ready, 1'b1);
    @(posedge clk); #1;

    cur_req = "R1"; set_fmt(2'b11, 0, 0, 0, 0); send(8'hA5); wait_idle();
    cur_req = "R1"; set_fmt(2'b00, 0, 0, 0, 0); send(8'hED); wait_idle();
    cur_req = "R2"; set_fmt(2'b00, 1, 0, 0, 0); send(8'h13); wait_idle();
    cur_req = "R2"; set_fmt(2'b01, 1, 0, 0, 0); send(8'h2A); wait_idle();
    cur_req = "R3"; set_fmt(2'b11, 1, 1, 1, 0); send(8'h07); wait_idle();
    cur_req = "R3"; set_fmt(2'b10, 0, 1, 0, 0); send(8'h55); wait_idle();
    cur_req = "R4"; set_fmt(2'b11, 0, 1, 0, 1); send(8'h00); wait_idle();
    cur_req = "R4"; set_fmt(2'b01, 0, 1, 1, 1); send(8'hFF); wait_idle();

    cur_req = "R8";
    set_fmt(2'b10, 1, 1, 1, 0); send(8'h3C);
    wait_cycles(40);
    set_fmt(2'b00, 0, 1, 0, 1);
    wait_idle();

    cur_req = "R7";
    set_fmt(2'b00, 0, 0, 0, 0); send(8'h1F);
    in_data = 8'h0A; in_valid = 1'b1;
    wait_idle();
    in_valid = 1'b0;
    wait_idle();

    cur_req = "R5";
    set_fmt(2'b11, 1, 1, 0, 0); send(8'hC3);
    wait_cycles(100);
    brk = 1'b1; in_valid = 1'b1; in_data = 8'h81;
    wait_cycles(60);
    brk = 1'b0;
    wait_cycles(2);
    in_valid = 1'b0;
    wait_idle();

    cur_req = "R6";
    set_fmt(2'b10, 1, 0, 0, 0); send(8'h66);
    wait_cycles(70);
    soft_rst = 1'b1;
    wait_cycles(1);
    soft_rst = 1'b0;
    wait_cycles(20);
    set_fmt(2'b01, 0, 1, 1, 0); send(8'h29); wait_idle();

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired during %s", cur_req);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule